// File: doc/BRIEF.md
# Branch Record Trace and Store Unit

This unit watches the control transfers that a processor core retires. Each transfer arrives as one event with a kind code, a source address and a destination address. Taken branches, interrupts and exceptions each form a branch record. A record is one word of twice the address width, with the source address in the low half and the destination address in the high half. Branches that are not taken are discarded.

A configuration port sets three enables. The first sends each record out on a trace output one cycle after its event. The second writes each record into a memory buffer through a write-request port. The buffer is described by a base address, a write index counted in records, and a size counted in records. The third enable chooses what happens when the last slot of the buffer is written. With the enable set, the unit raises a level interrupt request and stops storing. With it clear, the index returns to zero and logging continues, overwriting the oldest records.

A write that the memory side does not accept stays in a one-deep holding register until it is taken. If another storable event arrives while that register is full and not draining, the event is dropped and a sticky overflow flag is set.

Top module: `btrace_logger`

## Requirements
- R1: With control bit 6 set, every event of kind 01 (taken branch), 10 (interrupt) or 11 (exception) makes `trc_valid` high for exactly the next cycle. In that cycle `trc_rec` carries `{to, from}`: the source address in bits 31:0 and the destination address in bits 63:32.
- R2: With control bit 6 clear, `trc_valid` stays low whatever events arrive.
- R3: An event of kind 00 (branch not taken) produces no trace message and no memory write.
- R4: With control bit 7 set, each qualifying event is offered on the write port in the cycle after the event. The offer is `mem_req` high, `mem_addr` = base + 8 × index and `mem_data` = the record. The index advances by one when the write is accepted (`mem_req` and `mem_ready` both high).
- R5: While `mem_req` is high and `mem_ready` is low, the pending record is held unchanged and is not lost. A new event that arrives in the same cycle the pending record is accepted is stored next, with no gap.
- R6: A storable event that arrives while a record is pending and not being accepted is dropped and sets `overflow`. The flag stays set until a status write with bit 1 set; if a new overflow happens in the same cycle, the flag stays set.
- R7: With control bit 8 clear, accepting the write at index size−1 returns the index to 0 and storing continues; `irq` stays low.
- R8: With control bit 8 set, accepting the write at index size−1 returns the index to 0 and raises `irq`. While `irq` is high, no new event is stored. An event arriving in the very cycle of that final acceptance is not stored either, and does not count as an overflow.
- R9: `irq` is a level that stays high until a status write with bit 0 set, or a write to the index register, clears it. After that, storing resumes from the current index. A new raise in the same cycle as a clear wins.
- R10: Configuration writes select a register with `cfg_sel`: 0 holds control bits 6, 7 and 8; 1 the base address; 2 the write index; 3 the buffer size (9 bits); 4 the status, which clears flags by writing one (bit 0 clears `irq`, bit 1 clears `overflow`). After reset all registers are zero and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select for the write |
| cfg_wdata | input | 32 | Configuration write data |
| ev_valid | input | 1 | A retired control transfer is present |
| ev_kind | input | 2 | 00 not taken, 01 taken branch, 10 interrupt, 11 exception |
| ev_from | input | 32 | Source address of the transfer |
| ev_to | input | 32 | Destination address of the transfer |
| trc_valid | output | 1 | Trace message valid |
| trc_rec | output | 64 | Trace record {to, from} |
| mem_req | output | 1 | Buffer write request |
| mem_addr | output | 32 | Buffer write byte address |
| mem_data | output | 64 | Buffer write record |
| mem_ready | input | 1 | Memory accepts the write this cycle |
| wr_index | output | 8 | Current write index in records |
| irq | output | 1 | Buffer-full interrupt request level |
| overflow | output | 1 | Sticky dropped-event flag |

## Verification
The bench goes after the corner cases at the edges of the buffer and of the holding register:
- Events are sent while a write is stalled; a design with no proper holding register would overwrite the pending record or lose it.
- An event is sent in the same cycle a pending write is accepted; a design that got this wrong would report a false overflow or drop the record.
- The buffer is filled to its end in both modes; a wrong design would wrap into the interrupt mode, or keep writing past the end while the interrupt request is pending.
- The interrupt is cleared both by an acknowledge and by rewriting the index; a design that knew only one of these paths would never resume.
- A long stretch of mixed kinds, random back-pressure and interleaved clears checks that no sequence leads to a duplicated, reordered or misaddressed record.

// File: rtl/btl_pkg.sv
package btl_pkg;

   typedef enum logic [1:0] {
      EV_NOT_TAKEN = 2'b00,
      EV_BRANCH    = 2'b01,
      EV_INTR      = 2'b10,
      EV_EXCEPT    = 2'b11
   } ev_kind_e;

   typedef enum logic [2:0] {
      CSEL_CTL    = 3'd0,
      CSEL_BASE   = 3'd1,
      CSEL_INDEX  = 3'd2,
      CSEL_SIZE   = 3'd3,
      CSEL_STATUS = 3'd4
   } csel_e;

   localparam int CTL_TRACE_BIT = 6;
   localparam int CTL_STORE_BIT = 7;
   localparam int CTL_FULL_BIT  = 8;
   localparam int ST_IRQ_BIT    = 0;
   localparam int ST_OVF_BIT    = 1;

endpackage

// File: rtl/btl_cfg_regs.sv
module btl_cfg_regs
   import btl_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_sel,
   input  logic [ADDR_W-1:0] cfg_wdata,
   output logic              trc_en,
   output logic              sto_en,
   output logic              int_mode,
   output logic [ADDR_W-1:0] base_q,
   output logic [IDX_W:0]    size_q,
   output logic              idx_wr,
   output logic [IDX_W-1:0]  idx_wdata,
   output logic              clr_irq,
   output logic              clr_ovf
);

   wire unused_wdata = &{1'b0, cfg_wdata};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trc_en   <= 1'b0;
         sto_en   <= 1'b0;
         int_mode <= 1'b0;
         base_q   <= '0;
         size_q   <= '0;
      end else if (cfg_we) begin
         case (cfg_sel)
            CSEL_CTL: begin
               trc_en   <= cfg_wdata[CTL_TRACE_BIT];
               sto_en   <= cfg_wdata[CTL_STORE_BIT];
               int_mode <= cfg_wdata[CTL_FULL_BIT];
            end
            CSEL_BASE: base_q <= cfg_wdata;
            CSEL_SIZE: size_q <= cfg_wdata[IDX_W:0];
            default: ;
         endcase
      end
   end

   assign idx_wr    = cfg_we && (cfg_sel == CSEL_INDEX);
   assign idx_wdata = cfg_wdata[IDX_W-1:0];
   assign clr_irq   = cfg_we && (cfg_sel == CSEL_STATUS) && cfg_wdata[ST_IRQ_BIT];
   assign clr_ovf   = cfg_we && (cfg_sel == CSEL_STATUS) && cfg_wdata[ST_OVF_BIT];

endmodule

// File: rtl/btl_event_front.sv
module btl_event_front
   import btl_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int TRACE_PIPE = 1,
   localparam int REC_W     = 2 * ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_valid,
   input  logic [1:0]        ev_kind,
   input  logic [ADDR_W-1:0] ev_from,
   input  logic [ADDR_W-1:0] ev_to,
   input  logic              trc_en,
   output logic              qual,
   output logic [REC_W-1:0]  rec,
   output logic              trc_valid,
   output logic [REC_W-1:0]  trc_rec
);

   assign qual = ev_valid && (ev_kind != EV_NOT_TAKEN);
   assign rec  = {ev_to, ev_from};

   generate
      if (TRACE_PIPE != 0) begin : g_trace_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               trc_valid <= 1'b0;
               trc_rec   <= '0;
            end else begin
               trc_valid <= qual && trc_en;
               if (qual) trc_rec <= rec;
            end
         end
      end else begin : g_trace_comb
         wire unused_clk = &{1'b0, clk, rst_n};
         assign trc_valid = qual && trc_en;
         assign trc_rec   = rec;
      end
   endgenerate

endmodule

// File: rtl/btl_store_ctrl.sv
module btl_store_ctrl #(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 8,
   localparam int REC_W     = 2 * ADDR_W,
   localparam int REC_SHIFT = $clog2(REC_W / 8)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              qual,
   input  logic [REC_W-1:0]  rec,
   input  logic              sto_en,
   input  logic              int_mode,
   input  logic [ADDR_W-1:0] base_q,
   input  logic [IDX_W:0]    size_q,
   input  logic              idx_wr,
   input  logic [IDX_W-1:0]  idx_wdata,
   input  logic              clr_irq,
   input  logic              clr_ovf,
   input  logic              mem_ready,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [REC_W-1:0]  mem_data,
   output logic [IDX_W-1:0]  wr_index,
   output logic              irq,
   output logic              overflow
);

   localparam logic [IDX_W:0]   ONE_X = (IDX_W+1)'(1);
   localparam logic [IDX_W-1:0] ONE_I = IDX_W'(1);

   logic             hold_v;
   logic [REC_W-1:0] hold_d;
   logic [IDX_W-1:0] idx_q;
   logic             irq_q;
   logic             ovf_q;

   logic accept, at_end, fill_int, allow, take, load, ovf_set;

   always_comb begin
      accept   = hold_v && mem_ready;
      at_end   = ({1'b0, idx_q} + ONE_X) >= size_q;
      fill_int = accept && at_end && int_mode;
      allow    = sto_en && !irq_q && !fill_int;
      take     = qual && allow;
      load     = take && (!hold_v || accept);
      ovf_set  = take && hold_v && !accept;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_v <= 1'b0;
         hold_d <= '0;
      end else begin
         hold_v <= load || (hold_v && !accept);
         if (load) hold_d <= rec;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (idx_wr) begin
         idx_q <= idx_wdata;
      end else if (accept) begin
         idx_q <= at_end ? '0 : idx_q + ONE_I;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
         ovf_q <= 1'b0;
      end else begin
         if (fill_int)              irq_q <= 1'b1;
         else if (clr_irq || idx_wr) irq_q <= 1'b0;
         if (ovf_set)      ovf_q <= 1'b1;
         else if (clr_ovf) ovf_q <= 1'b0;
      end
   end

   assign mem_req  = hold_v;
   assign mem_data = hold_d;
   assign mem_addr = base_q + (ADDR_W'(idx_q) << REC_SHIFT);
   assign wr_index = idx_q;
   assign irq      = irq_q;
   assign overflow = ovf_q;

endmodule

// File: rtl/btrace_logger.sv
module btrace_logger
   import btl_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int IDX_W      = 8,
   parameter int TRACE_PIPE = 1,
   localparam int REC_W     = 2 * ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_sel,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic              ev_valid,
   input  logic [1:0]        ev_kind,
   input  logic [ADDR_W-1:0] ev_from,
   input  logic [ADDR_W-1:0] ev_to,
   output logic              trc_valid,
   output logic [REC_W-1:0]  trc_rec,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [REC_W-1:0]  mem_data,
   input  logic              mem_ready,
   output logic [IDX_W-1:0]  wr_index,
   output logic              irq,
   output logic              overflow
);

   generate
      if (ADDR_W % 8 != 0 || ADDR_W < CTL_FULL_BIT + 1) begin : g_bad_addr_w
         $error("btrace_logger: ADDR_W must be a byte multiple of at least 16");
      end
      if (IDX_W < 1 || IDX_W + 1 > ADDR_W) begin : g_bad_idx_w
         $error("btrace_logger: IDX_W out of range");
      end
   endgenerate

   logic              trc_en, sto_en, int_mode;
   logic [ADDR_W-1:0] base_q;
   logic [IDX_W:0]    size_q;
   logic              idx_wr, clr_irq, clr_ovf;
   logic [IDX_W-1:0]  idx_wdata;
   logic              qual;
   logic [REC_W-1:0]  rec;

   btl_cfg_regs #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .trc_en    (trc_en),
      .sto_en    (sto_en),
      .int_mode  (int_mode),
      .base_q    (base_q),
      .size_q    (size_q),
      .idx_wr    (idx_wr),
      .idx_wdata (idx_wdata),
      .clr_irq   (clr_irq),
      .clr_ovf   (clr_ovf)
   );

   btl_event_front #(.ADDR_W(ADDR_W), .TRACE_PIPE(TRACE_PIPE)) u_front (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev_valid  (ev_valid),
      .ev_kind   (ev_kind),
      .ev_from   (ev_from),
      .ev_to     (ev_to),
      .trc_en    (trc_en),
      .qual      (qual),
      .rec       (rec),
      .trc_valid (trc_valid),
      .trc_rec   (trc_rec)
   );

   btl_store_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .qual      (qual),
      .rec       (rec),
      .sto_en    (sto_en),
      .int_mode  (int_mode),
      .base_q    (base_q),
      .size_q    (size_q),
      .idx_wr    (idx_wr),
      .idx_wdata (idx_wdata),
      .clr_irq   (clr_irq),
      .clr_ovf   (clr_ovf),
      .mem_ready (mem_ready),
      .mem_req   (mem_req),
      .mem_addr  (mem_addr),
      .mem_data  (mem_data),
      .wr_index  (wr_index),
      .irq       (irq),
      .overflow  (overflow)
   );

endmodule

// File: rtl/btl_checker.sv
module btl_checker #(
   parameter int ADDR_W     = 32,
   parameter int TRACE_PIPE = 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cfg_we,
   input logic [2:0]          cfg_sel,
   input logic [ADDR_W-1:0]   cfg_wdata,
   input logic                ev_valid,
   input logic [1:0]          ev_kind,
   input logic [ADDR_W-1:0]   ev_from,
   input logic [ADDR_W-1:0]   ev_to,
   input logic                trc_valid,
   input logic [2*ADDR_W-1:0] trc_rec,
   input logic                mem_req,
   input logic                mem_ready,
   input logic [2*ADDR_W-1:0] mem_data,
   input logic                irq,
   input logic                overflow,
   input logic                trc_en
);

   wire unused_cfg = &{1'b0, cfg_wdata};

   wire st_wr      = cfg_we && (cfg_sel == 3'd4);
   wire irq_clear  = (st_wr && cfg_wdata[0]) || (cfg_we && (cfg_sel == 3'd2));
   wire ovf_clear  = st_wr && cfg_wdata[1];

   generate
      if (TRACE_PIPE != 0) begin : g_trace_props
         // R1
         a_r1_trace_record: assert property (@(posedge clk) disable iff (!rst_n)
            (ev_valid && ev_kind != 2'b00 && trc_en) |=>
               (trc_valid && trc_rec == {$past(ev_to), $past(ev_from)}));
         // R2
         a_r2_trace_off: assert property (@(posedge clk) disable iff (!rst_n)
            !trc_en |=> !trc_valid);
         // R3
         a_r3_not_taken_silent: assert property (@(posedge clk) disable iff (!rst_n)
            (!ev_valid || ev_kind == 2'b00) |=> !trc_valid);
      end
   endgenerate

   // R5
   a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_data)));

   // R6
   a_r6_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && !ovf_clear) |=> overflow);

   // R8
   a_r8_halt_no_store: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !mem_req) |=> !mem_req);

   // R9
   a_r9_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clear) |=> irq);

endmodule

bind btrace_logger btl_checker #(.ADDR_W(ADDR_W), .TRACE_PIPE(TRACE_PIPE)) u_chk (.*);

// File: tb/btrace_logger_tb.sv
module btrace_logger_tb;

   localparam int AW = 32;
   localparam int IW = 8;
   localparam int RW = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [2:0]    cfg_sel = '0;
   logic [AW-1:0] cfg_wdata = '0;
   logic          ev_valid = 1'b0;
   logic [1:0]    ev_kind = '0;
   logic [AW-1:0] ev_from = '0;
   logic [AW-1:0] ev_to = '0;
   logic          mem_ready = 1'b0;
   logic          trc_valid, mem_req, irq, overflow;
   logic [RW-1:0] trc_rec, mem_data;
   logic [AW-1:0] mem_addr;
   logic [IW-1:0] wr_index;

   always #2 clk = ~clk;

   btrace_logger u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_from(ev_from), .ev_to(ev_to),
      .trc_valid(trc_valid), .trc_rec(trc_rec), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_data(mem_data), .mem_ready(mem_ready), .wr_index(wr_index), .irq(irq),
      .overflow(overflow)
   );

   int    n_chk = 0;
   int    n_fail = 0;
   string phase = "R10";

   task automatic check(input string req, input string what,
                        input logic [RW-1:0] act, input logic [RW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s [%s]: actual %h expected %h", req, what, phase, act, exp);
      end
   endtask

   task automatic report;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   // Behavioural reference model
   bit            m_tr, m_st, m_int, m_irq, m_ovf, m_trc_v;
   logic [AW-1:0] m_base;
   int            m_idx, m_size;
   logic [RW-1:0] m_q[$];
   logic [RW-1:0] m_trc_d;

   always @(posedge clk or negedge rst_n) begin : ref_model
      bit qual, acc, at_end, fill, allow, ovf_set;
      logic [RW-1:0] rec;
      if (!rst_n) begin
         m_tr = 0; m_st = 0; m_int = 0; m_irq = 0; m_ovf = 0; m_trc_v = 0;
         m_base = '0; m_idx = 0; m_size = 0; m_trc_d = '0;
         m_q.delete();
      end else begin
         qual    = ev_valid && (ev_kind != 2'b00);
         rec     = {ev_to, ev_from};
         acc     = (m_q.size() != 0) && mem_ready;
         at_end  = (m_idx + 1) >= m_size;
         fill    = acc && at_end && m_int;
         allow   = m_st && !m_irq && !fill;
         ovf_set = 0;
         m_trc_v = qual && m_tr;
         if (qual) m_trc_d = rec;
         if (acc) begin
            void'(m_q.pop_front());
            m_idx = at_end ? 0 : m_idx + 1;
         end
         if (qual && allow) begin
            if (m_q.size() == 0) m_q.push_back(rec);
            else ovf_set = 1;
         end
         if (cfg_we) begin
            case (cfg_sel)
               3'd0: begin m_tr = cfg_wdata[6]; m_st = cfg_wdata[7]; m_int = cfg_wdata[8]; end
               3'd1: m_base = cfg_wdata;
               3'd2: begin m_idx = int'(cfg_wdata[IW-1:0]); m_irq = 0; end
               3'd3: m_size = int'(cfg_wdata[IW:0]);
               3'd4: begin
                  if (cfg_wdata[0]) m_irq = 0;
                  if (cfg_wdata[1]) m_ovf = 0;
               end
               default: ;
            endcase
         end
         if (fill) m_irq = 1;
         if (ovf_set) m_ovf = 1;
      end
   end

   // Per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         check("R1", "trc_valid", RW'(trc_valid), RW'(m_trc_v));
         if (m_trc_v) check("R1", "trc_rec", trc_rec, m_trc_d);
         check("R4", "mem_req", RW'(mem_req), RW'(m_q.size() != 0));
         if (m_q.size() != 0) begin
            check("R4", "mem_addr", RW'(mem_addr), RW'(m_base + AW'(m_idx * 8)));
            check("R5", "mem_data", mem_data, m_q[0]);
         end
         check("R7", "wr_index", RW'(wr_index), RW'(m_idx));
         check("R8", "irq", RW'(irq), RW'(m_irq));
         check("R6", "overflow", RW'(overflow), RW'(m_ovf));
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cfg(input logic [2:0] sel, input logic [AW-1:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic ev(input logic [1:0] k, input logic [AW-1:0] f, input logic [AW-1:0] t);
      @(negedge clk);
      ev_valid = 1'b1; ev_kind = k; ev_from = f; ev_to = t;
      @(negedge clk);
      ev_valid = 1'b0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL R10 watchdog: actual timeout expected completion");
      report();
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      // R10 reset state
      check("R10", "reset trc_valid", RW'(trc_valid), '0);
      check("R10", "reset mem_req", RW'(mem_req), '0);
      check("R10", "reset wr_index", RW'(wr_index), '0);
      check("R10", "reset irq", RW'(irq), '0);
      check("R10", "reset overflow", RW'(overflow), '0);
      rst_n = 1'b1;
      idle(2);

      // R1 trace on, each qualifying kind; R3 not taken
      phase = "R1";
      cfg(3'd0, 32'h0000_0040);
      ev(2'b01, 32'h0000_1000, 32'h0000_2000);
      ev(2'b10, 32'h0000_1004, 32'hFFFF_0100);
      ev(2'b11, 32'h0000_1008, 32'hFFFF_0200);
      phase = "R3";
      ev(2'b00, 32'h0000_100C, 32'h0000_3000);
      check("R3", "no trace for not taken", RW'(trc_valid), '0);

      // R2 trace off
      phase = "R2";
      cfg(3'd0, 32'h0);
      ev(2'b01, 32'h0000_2000, 32'h0000_4000);
      check("R2", "trace disabled", RW'(trc_valid), '0);

      // R4 / R7 store with wrap
      phase = "R7";
      mem_ready = 1'b1;
      cfg(3'd1, 32'h8000_1000);
      cfg(3'd3, 32'd4);
      cfg(3'd2, 32'd0);
      cfg(3'd0, 32'h0000_0080);
      for (int i = 0; i < 6; i++) ev(2'b01, 32'h100 + 32'(i), 32'h200 + 32'(i));
      ev(2'b00, 32'h0, 32'h0);
      idle(3);
      check("R7", "index after six stores in four slots", RW'(wr_index), RW'(2));
      check("R7", "no irq in wrap mode", RW'(irq), '0);

      // R5 / R6 back-pressure and overflow
      phase = "R5";
      mem_ready = 1'b0;
      ev(2'b10, 32'hAAAA_0000, 32'hBBBB_0000);
      idle(3);
      check("R5", "request held under stall", RW'(mem_req), RW'(1));
      phase = "R6";
      ev(2'b11, 32'hCCCC_0000, 32'hDDDD_0000);
      idle(1);
      check("R6", "overflow set", RW'(overflow), RW'(1));
      mem_ready = 1'b1;
      idle(3);
      cfg(3'd4, 32'h2);
      idle(1);
      check("R6", "overflow cleared", RW'(overflow), '0);

      // R5 accept and new event in the same cycle
      phase = "R5";
      mem_ready = 1'b0;
      ev(2'b01, 32'h1111_0000, 32'h2222_0000);
      @(negedge clk);
      mem_ready = 1'b1; ev_valid = 1'b1; ev_kind = 2'b01;
      ev_from = 32'h3333_0000; ev_to = 32'h4444_0000;
      @(negedge clk);
      ev_valid = 1'b0;
      check("R5", "no false overflow", RW'(overflow), '0);
      idle(2);

      // R8 interrupt mode
      phase = "R8";
      cfg(3'd3, 32'd3);
      cfg(3'd2, 32'd0);
      cfg(3'd0, 32'h0000_0180);
      for (int i = 0; i < 3; i++) ev(2'b01, 32'h500 + 32'(i), 32'h600 + 32'(i));
      idle(2);
      check("R8", "irq raised at end", RW'(irq), RW'(1));
      check("R8", "index back to zero", RW'(wr_index), '0);
      ev(2'b10, 32'h700, 32'h800);
      check("R8", "no store while irq", RW'(mem_req), '0);
      idle(4);
      check("R9", "irq still held", RW'(irq), RW'(1));

      // R9 clearing paths
      phase = "R9";
      cfg(3'd4, 32'h1);
      check("R9", "irq cleared by status", RW'(irq), '0);
      ev(2'b01, 32'h900, 32'hA00);
      check("R9", "store resumes", RW'(mem_req) | RW'(wr_index != 0), RW'(1));
      for (int i = 0; i < 3; i++) ev(2'b11, 32'hB00 + 32'(i), 32'hC00 + 32'(i));
      idle(2);
      check("R8", "irq raised again", RW'(irq), RW'(1));
      cfg(3'd2, 32'd1);
      check("R9", "irq cleared by index write", RW'(irq), '0);
      check("R9", "index rewritten", RW'(wr_index), RW'(1));

      // Mixed random traffic
      phase = "R5";
      cfg(3'd3, 32'd5);
      cfg(3'd0, 32'h0000_01C0);
      for (int c = 0; c < 4000; c++) begin
         @(negedge clk);
         ev_valid  = ($urandom % 2) == 0;
         ev_kind   = 2'($urandom);
         ev_from   = $urandom;
         ev_to     = $urandom;
         mem_ready = ($urandom % 4) != 0;
         cfg_we    = ($urandom % 16) == 0;
         cfg_sel   = (($urandom % 3) == 0) ? 3'd2 : 3'd4;
         cfg_wdata = 32'($urandom % 4);
         if (c == 2000) begin
            cfg_we = 1'b1; cfg_sel = 3'd0; cfg_wdata = 32'h0000_00C0;
            phase = "R7";
         end
      end
      @(negedge clk);
      ev_valid = 1'b0; cfg_we = 1'b0; mem_ready = 1'b1;
      idle(4);

      report();
      $finish;
   end

endmodule